// File: doc/BRIEF.md
# Dual Parallel Port Group

This block provides 48 general-purpose digital lines, organised as two identical groups of three 8-bit ports, named A, B and C. A host reaches every register over a simple bus with 8-bit data and a 4-bit address. Writes take effect at the clock edge. Reads are combinational. Each line has an output value, an output enable and an input. The pad ring combines these into a tri-state pin.

Each group has one control register, which takes two kinds of write:
- **Direction word.** Ports A and B are switched between input and output a whole byte at a time. Port C is switched one nibble at a time. This write also clears every output latch in the group.
- **Single-bit write.** One bit of port C is set or cleared. Directions are left as they are.

When the host reads a port, input bits return the live pin level and output bits return the latch contents.

Top module: `dio_dual_group`

## Requirements
- R1: Group g (g = 0, 1) places port A at offset 4g, port B at 4g+1, port C at 4g+2 and its control register at 4g+3. Line g*24 + p*8 + b carries bit b of port p, where A=0, B=1 and C=2.
- R2: After reset, every line is an input (`pin_oe` all zero) and every output latch holds zero (`pin_out` all zero).
- R3: A write to a port offset always loads that port's latch, whatever the direction. `pin_out` always shows the latch contents, and `pin_oe` alone decides whether a line is driven.
- R4: A control write with bit 7 = 1 sets the directions of its group. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes the upper nibble of port C an input, and bit 0 = 1 makes the lower nibble of port C an input. A zero in any of these bits makes that part an output, so 0x80 makes the whole group output.
- R5: A direction write clears all three latches of its own group in the same cycle. The other group's latches are unchanged.
- R6: A control write with bit 7 = 0 loads bit 0 of the data into bit index data[3:1] of that group's port C latch. The other latch bits and all directions are unchanged.
- R7: A read of a port returns `pin_in` for bits that are inputs and the latch value for bits that are outputs. This is resolved per nibble on port C.
- R8: A read of a control offset returns zero. Offsets at or above 4 × NUM_GROUPS read as zero, and writes to them change no latch and no direction.
- R9: The two groups are independent. A write to one group changes no state in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 48 | Sampled pin levels |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Per-line output enable |

## Verification
The hardest state to reach is port C with its two nibbles in opposite directions while its latch holds data. A direction write wipes the latch, so reads that mix live pins with latch bits only show up if the stimulus first writes the direction word and then reloads the latch, through either a port write or single-bit writes. The bench walks port C through both split configurations in that order. It also loads a latch in the other group beforehand, to show that a clear stays within its own group. A port is also written while it is an input, and the result is seen at once on `pin_out`. This proves the latch is written regardless of direction, before a later direction change could hide it.

// File: rtl/dio_pkg.sv
package dio_pkg;

   // Control word bit positions. A neighbour that writes these words depends on them.
   localparam int CW_MODE  = 7;
   localparam int CW_A_IN  = 4;
   localparam int CW_CH_IN = 3;
   localparam int CW_B_IN  = 1;
   localparam int CW_CL_IN = 0;

   typedef struct packed {
      logic a_in;
      logic b_in;
      logic ch_in;
      logic cl_in;
   } dio_dir_t;

   localparam dio_dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};

   function automatic dio_dir_t decode_dir(input logic [7:0] w);
      dio_dir_t d;
      d.a_in  = w[CW_A_IN];
      d.b_in  = w[CW_B_IN];
      d.ch_in = w[CW_CH_IN];
      d.cl_in = w[CW_CL_IN];
      return d;
   endfunction

endpackage

// File: rtl/dio_ctrl.sv
module dio_ctrl
   import dio_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output dio_dir_t          dir,
   output logic              dir_we,
   output logic              bit_we,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              bit_val
);

   assign dir_we  = ctrl_we &  wdata[CW_MODE];
   assign bit_we  = ctrl_we & ~wdata[CW_MODE];
   assign bit_idx = wdata[IDX_W:1];
   assign bit_val = wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir <= DIR_RESET;
      else if (dir_we) dir <= decode_dir(wdata[7:0]);
   end

   // R6: a single-bit write leaves the directions alone
   p_bitset_keeps_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_we |=> $stable(dir));

endmodule

// File: rtl/dio_port.sv
module dio_port #(
   parameter int DATA_W      = 8,
   parameter bit SPLIT_DIR   = 1'b0,
   parameter bit HAS_BIT_SET = 1'b0,
   localparam int IDX_W = $clog2(DATA_W),
   localparam int HALF  = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr,
   input  logic              bit_we,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              bit_val,
   input  logic              lo_in,
   input  logic              hi_in,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] latch,
   output logic [DATA_W-1:0] oe,
   output logic [DATA_W-1:0] rdata
);

   logic bit_we_eff;

   generate
      if (HAS_BIT_SET) begin : g_bitset
         assign bit_we_eff = bit_we;
         p_bit_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_we && !clr && !we) |=> latch[$past(bit_idx)] == $past(bit_val));
      end else begin : g_nobitset
         assign bit_we_eff = 1'b0;
      end

      if (SPLIT_DIR) begin : g_split
         assign oe = {{(DATA_W-HALF){~hi_in}}, {HALF{~lo_in}}};
      end else begin : g_whole
         assign oe = {DATA_W{~lo_in}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          latch <= '0;
      else if (clr)        latch <= '0;
      else if (we)         latch <= wdata;
      else if (bit_we_eff) latch[bit_idx] <= bit_val;
   end

   assign rdata = (latch & oe) | (pin_in & ~oe);

   p_port_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> latch == $past(wdata));
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> latch == '0);

endmodule

// File: rtl/dio_group.sv
module dio_group
   import dio_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int NPORT = 3,
   localparam int GW    = NPORT * DATA_W,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [1:0]        off,
   input  logic [DATA_W-1:0] wdata,
   input  logic [GW-1:0]     pin_in,
   output logic [GW-1:0]     pin_out,
   output logic [GW-1:0]     pin_oe,
   output logic [DATA_W-1:0] rdata
);

   dio_dir_t           dir;
   logic               dir_we, bit_we, bit_val;
   logic [IDX_W-1:0]   bit_idx;
   logic [DATA_W-1:0]  prd [NPORT];
   logic [NPORT-1:0]   lo_in, hi_in;

   dio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk, .rst_n,
      .ctrl_we (sel_we && off == 2'd3),
      .wdata,
      .dir, .dir_we, .bit_we, .bit_idx, .bit_val
   );

   assign lo_in = {dir.cl_in, dir.b_in, dir.a_in};
   assign hi_in = {dir.ch_in, dir.b_in, dir.a_in};

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         dio_port #(
            .DATA_W      (DATA_W),
            .SPLIT_DIR   (p == NPORT-1),
            .HAS_BIT_SET (p == NPORT-1)
         ) u_port (
            .clk, .rst_n,
            .we      (sel_we && off == 2'(p)),
            .wdata,
            .clr     (dir_we),
            .bit_we,
            .bit_idx,
            .bit_val,
            .lo_in   (lo_in[p]),
            .hi_in   (hi_in[p]),
            .pin_in  (pin_in [p*DATA_W +: DATA_W]),
            .latch   (pin_out[p*DATA_W +: DATA_W]),
            .oe      (pin_oe [p*DATA_W +: DATA_W]),
            .rdata   (prd[p])
         );
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (off != 2'd3) rdata = prd[off];
   end

   // R4: direction word maps to the output enables of ports A and C-upper
   p_dir_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> (pin_oe[DATA_W-1:0] == {DATA_W{~$past(wdata[CW_A_IN])}}) &&
                 (pin_oe[GW-1] == ~$past(wdata[CW_CH_IN])));

endmodule

// File: rtl/dio_dual_group.sv
module dio_dual_group #(
   parameter int NUM_GROUPS = 2,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   localparam int GW    = 3 * DATA_W,
   localparam int PIN_W = NUM_GROUPS * GW,
   localparam int GRP_W = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("dio_dual_group: DATA_W must be 8");
      end
      if (4 * NUM_GROUPS > (1 << ADDR_W)) begin : g_bad_map
         $error("dio_dual_group: address space too small for NUM_GROUPS");
      end
   endgenerate

   logic [GRP_W-1:0]  grp;
   logic [1:0]        off;
   logic              mapped;
   logic [DATA_W-1:0] grd [NUM_GROUPS];

   assign grp    = bus_addr[ADDR_W-1:2];
   assign off    = bus_addr[1:0];
   assign mapped = (int'(grp) < NUM_GROUPS);

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         dio_group #(.DATA_W(DATA_W)) u_grp (
            .clk, .rst_n,
            .sel_we  (bus_wr && mapped && int'(grp) == g),
            .off,
            .wdata   (bus_wdata),
            .pin_in  (pin_in [g*GW +: GW]),
            .pin_out (pin_out[g*GW +: GW]),
            .pin_oe  (pin_oe [g*GW +: GW]),
            .rdata   (grd[g])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (mapped && int'(grp) == g) bus_rdata = grd[g];
   end

   // R8: writes outside the map leave every line untouched
   p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !mapped) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/dio_dual_group_tb.sv
module dio_dual_group_tb;

   typedef struct {
      int          kind;   // 0 read data, 1 pin_out, 2 pin_oe
      logic [47:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in = '0;
   logic [47:0] pin_out, pin_oe;

   item_t q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   dio_dual_group u_dut (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
      .pin_in, .pin_out, .pin_oe
   );

   // monitor: compares queued expectations just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() != 0) begin
            item_t it;
            logic [47:0] act;
            it = q.pop_front();
            case (it.kind)
               0:       act = {40'b0, bus_rdata};
               1:       act = pin_out;
               default: act = pin_oe;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string r);
      @(negedge clk);
      bus_addr = a;
      q.push_back('{kind: 0, exp: {40'b0, e}, req: r});
   endtask

   task automatic exp_pins(input logic [47:0] o, input logic [47:0] e, input string r);
      @(negedge clk);
      q.push_back('{kind: 1, exp: o, req: r});
      q.push_back('{kind: 2, exp: e, req: r});
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      pin_in = 48'h123456_789ABC;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state, R1 map, R7 input reads
      exp_pins(48'h0, 48'h0, "R2");
      exp_rd(4'd0, 8'hBC, "R2");
      exp_rd(4'd6, 8'h12, "R1");

      // R3 write while input: latch visible, not driven, read still pins
      wr(4'd1, 8'h3C);
      exp_pins(48'h000000_003C00, 48'h0, "R3");
      exp_rd(4'd1, 8'h9A, "R3");

      // R4 / R5: 0x80 makes group 0 output and clears its latches
      wr(4'd3, 8'h80);
      exp_pins(48'h0, 48'h000000_FFFFFF, "R4");
      exp_rd(4'd1, 8'h00, "R5");

      // R7 output reads latch, input reads pins
      wr(4'd0, 8'hA5);
      wr(4'd2, 8'h0F);
      wr(4'd5, 8'h77);
      exp_pins(48'h007700_0F00A5, 48'h000000_FFFFFF, "R3");
      exp_rd(4'd0, 8'hA5, "R7");
      exp_rd(4'd5, 8'h34, "R7");

      // R6 single-bit writes on port C: set bit 6, clear bit 0
      wr(4'd3, 8'h0D);
      wr(4'd3, 8'h00);
      exp_rd(4'd2, 8'h4E, "R6");
      exp_pins(48'h007700_4E00A5, 48'h000000_FFFFFF, "R6");

      // R4 upper nibble of C input; R5 clear stays in group 0 (R9)
      wr(4'd3, 8'h88);
      exp_pins(48'h007700_000000, 48'h000000_0FFFFF, "R5");
      exp_rd(4'd2, 8'h70, "R7");
      wr(4'd2, 8'hFF);
      exp_rd(4'd2, 8'h7F, "R7");

      // R4 lower nibble of C input, upper output
      wr(4'd3, 8'h81);
      exp_pins(48'h007700_000000, 48'h000000_F0FFFF, "R4");
      exp_rd(4'd2, 8'h08, "R7");

      // R4 ports A and B input, C output
      wr(4'd3, 8'h92);
      exp_pins(48'h007700_000000, 48'h000000_FF0000, "R4");

      // R9: group 1 direction word leaves group 0 latch intact
      wr(4'd2, 8'h3C);
      wr(4'd7, 8'h80);
      exp_pins(48'h000000_3C0000, 48'hFFFFFF_FF0000, "R9");

      // R6 / R1: bit 3 of group 1 port C via control at offset 7
      wr(4'd7, 8'h07);
      exp_pins(48'h080000_3C0000, 48'hFFFFFF_FF0000, "R6");
      exp_rd(4'd6, 8'h08, "R7");

      // R8 unmapped writes ignored, control and unmapped reads zero
      wr(4'd9, 8'hFF);
      wr(4'd15, 8'h80);
      exp_pins(48'h080000_3C0000, 48'hFFFFFF_FF0000, "R8");
      exp_rd(4'd9, 8'h00, "R8");
      exp_rd(4'd3, 8'h00, "R8");
      exp_rd(4'd7, 8'h00, "R8");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      finish_run();
   end

endmodule